// File: doc/BRIEF.md
# Per-Thread Commit Squash Controller

This block tracks the retirement-side state of every hardware thread in a multithreaded out-of-order core. It decides, for each thread and each cycle, whether the thread needs to be squashed. It also sends the earlier pipeline stages the information they need to discard wrong-path work. There are four squash sources:

- an execute-stage mispredict report;
- a trap whose squash is delayed by a fixed latency;
- an external context squash;
- a fetch fault, which stays pending until fetch withdraws it.

A mispredict report is only honoured if it is not older-than-stale. For each thread the block keeps the sequence number of its youngest valid instruction and rejects any report that names a younger one.

The reorder buffer appears only through a few per-thread inputs: done-squashing, empty and the head sequence number. The block returns a per-thread gate that stops newly renamed instructions from being inserted while that thread is squashing. A counter of squashing threads is kept alongside.

Top module: `commit_squash_ctrl`

## Requirements
- R1: After a synchronous active-low reset every thread is Idle, the youngest valid number is 0, no broadcast is valid, the broadcast number and PC read 0, and the squash count is 0. Per-thread fields are packed with thread t at bits [t*W +: W]. State codes on `state_o` (3 bits per thread) are: 0 Idle, 1 Running, 2 Squashing, 3 TrapWait, 4 FaultWait.
- R2: A thread in Idle moves to Running when `go_i` is high for it.
- R3: An execute squash is accepted when the thread is not in TrapWait and the requested number is less than or equal to the thread's youngest valid number. On acceptance, one edge later, the broadcast carries the requested number and `ex_pc_i`, and the thread is in Squashing.
- R4: When `ex_incl_i` is set on an accepted execute squash, the broadcast number is the requested number minus one, modulo 2^SEQ_W. The youngest valid number takes that value.
- R5: An execute squash naming a number younger than the youngest valid number, or arriving in TrapWait, produces no broadcast and no state change.
- R6: A trap request accepted in a state other than Squashing or TrapWait (and with no countdown running) moves the thread to TrapWait. A full squash broadcast follows exactly TRAP_LAT+1 edges after the request edge.
- R7: A full squash (expired trap or `ctx_sq_i`) broadcasts 0 when `rob_empty_i` is set, and otherwise `rob_head_i` minus one, modulo 2^SEQ_W. It carries `restart_pc_i` and clears the youngest valid number to 0.
- R8: An expired trap and a context squash in the same cycle produce a single full squash, and the squash count rises by at most one.
- R9: `rob_done_i` in Squashing returns the thread to Running. `sq_count_o` always equals the number of threads in Squashing.
- R10: A fetch fault moves the thread to FaultWait unless it is in TrapWait or Squashing. `fault_clr_i` in FaultWait returns the thread to Running.
- R11: `insert_o` equals `rename_vld_i` except while the thread is in Squashing, when it is 0. An accepted insert without a squash makes `rename_seq_i` the youngest valid number.
- R12: The broadcast valid bit is high for exactly one cycle per accepted squash event. It sits low in every cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go_i | input | NUM_THREADS | Start thread from Idle |
| rename_vld_i | input | NUM_THREADS | Renamed instruction offered for insertion |
| rename_seq_i | input | NUM_THREADS*SEQ_W | Sequence number of the offered instruction |
| ex_vld_i | input | NUM_THREADS | Execute-stage squash request |
| ex_seq_i | input | NUM_THREADS*SEQ_W | Sequence number of the squashing instruction |
| ex_incl_i | input | NUM_THREADS | Squash includes the squashing instruction |
| ex_pc_i | input | NUM_THREADS*PC_W | Redirect PC from execute |
| trap_req_i | input | NUM_THREADS | Trap raised at commit |
| ctx_sq_i | input | NUM_THREADS | External context squash |
| fault_i | input | NUM_THREADS | Fault reported by fetch |
| fault_clr_i | input | NUM_THREADS | Fetch withdraws its fault |
| rob_done_i | input | NUM_THREADS | Reorder buffer finished squashing |
| rob_empty_i | input | NUM_THREADS | Reorder buffer empty for thread |
| rob_head_i | input | NUM_THREADS*SEQ_W | Head sequence number |
| restart_pc_i | input | NUM_THREADS*PC_W | Restart PC for full squashes |
| state_o | output | NUM_THREADS*3 | Thread state codes |
| bc_vld_o | output | NUM_THREADS | Squash broadcast valid |
| bc_seq_o | output | NUM_THREADS*SEQ_W | Broadcast done sequence number |
| bc_pc_o | output | NUM_THREADS*PC_W | Broadcast redirect PC |
| insert_o | output | NUM_THREADS | Insertion allowed this cycle |
| sq_count_o | output | $clog2(NUM_THREADS+1) | Threads currently squashing |

## Verification
The bench builds the block with two threads, a 6-bit sequence number, a 12-bit PC and a trap latency of 3. The narrow sequence number makes the minus-one wrap from a head number of 0 reachable, and random sequence values often land on both sides of the youngest valid number. Two threads let squashes, trap countdowns and done-squashing overlap across threads, so the shared count sees simultaneous enter and leave events. The latency of 3 leaves room to inject a context squash exactly on the expiry cycle and execute squashes during the wait.

// File: rtl/csq_pkg.sv
// Shared types for the commit squash controller.
package csq_pkg;
    localparam int ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_SQUASH = 3'd2,
        ST_TRAPW  = 3'd3,
        ST_FAULTW = 3'd4
    } thr_state_e;
endpackage

// File: rtl/csq_trap_timer.sv
// Trap latency countdown for one thread.
// Loads TRAP_LAT on load_i, counts down each cycle, and raises a sticky
// expiry flag on the edge where the count leaves 1. The flag is dropped
// when the owner consumes it. Assumes load_i only while not busy.
module csq_trap_timer #(
    parameter int TRAP_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic consume_i,
    output logic busy_o,
    output logic flag_o
);
    localparam int CW = $clog2(TRAP_LAT + 1);

    logic [CW-1:0] cnt_q;
    logic          flag_q;
    logic          expire;

    assign expire = (cnt_q == CW'(1));
    assign busy_o = (cnt_q != '0);
    assign flag_o = flag_q;

    // Countdown register and sticky expiry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (load_i)
                cnt_q <= CW'(TRAP_LAT);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            flag_q <= expire | (flag_q & ~consume_i);
        end
    end

    p_expire_after_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(cnt_q) == CW'(1));
endmodule

// File: rtl/csq_thread.sv
// Squash arbitration and state for one thread.
// Order inside a cycle: done-squashing, start, fetch fault and clear,
// then the full squash (trap expiry or context), then the execute
// squash, then insertion and trap request. Broadcast outputs are
// registered and valid for one cycle. enter_o/leave_o report transitions
// into and out of Squashing for the shared counter.
module csq_thread
    import csq_pkg::*;
#(
    parameter int SEQ_W    = 6,
    parameter int PC_W     = 12,
    parameter int TRAP_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             rename_vld_i,
    input  logic [SEQ_W-1:0] rename_seq_i,
    input  logic             ex_vld_i,
    input  logic [SEQ_W-1:0] ex_seq_i,
    input  logic             ex_incl_i,
    input  logic [PC_W-1:0]  ex_pc_i,
    input  logic             trap_req_i,
    input  logic             ctx_sq_i,
    input  logic             fault_i,
    input  logic             fault_clr_i,
    input  logic             rob_done_i,
    input  logic             rob_empty_i,
    input  logic [SEQ_W-1:0] rob_head_i,
    input  logic [PC_W-1:0]  restart_pc_i,
    output thr_state_e       state_o,
    output logic             bc_vld_o,
    output logic [SEQ_W-1:0] bc_seq_o,
    output logic [PC_W-1:0]  bc_pc_o,
    output logic             insert_o,
    output logic             enter_o,
    output logic             leave_o
);
    thr_state_e       state_q, state_d, s_eff;
    logic [SEQ_W-1:0] young_q, young_d;
    logic             bc_vld_q, bc_vld_d;
    logic [SEQ_W-1:0] bc_seq_q, bc_seq_d;
    logic [PC_W-1:0]  bc_pc_q, bc_pc_d;
    logic             trap_flag, trap_busy, trap_load;
    logic             full_sq, ex_ok;

    // Delay between a trap request and its squash.
    csq_trap_timer #(.TRAP_LAT(TRAP_LAT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (trap_load),
        .consume_i (full_sq),
        .busy_o    (trap_busy),
        .flag_o    (trap_flag)
    );

    assign insert_o = rename_vld_i && (state_q != ST_SQUASH);
    assign full_sq  = trap_flag | ctx_sq_i;

    // Effective state after done-squash, start and fetch-fault handling.
    always_comb begin
        s_eff   = state_q;
        leave_o = 1'b0;
        if (state_q == ST_SQUASH && rob_done_i) begin
            s_eff   = ST_RUN;
            leave_o = 1'b1;
        end
        if (s_eff == ST_IDLE && go_i)
            s_eff = ST_RUN;
        if (fault_i && s_eff != ST_TRAPW && s_eff != ST_SQUASH)
            s_eff = ST_FAULTW;
        if (fault_clr_i && s_eff == ST_FAULTW)
            s_eff = ST_RUN;
    end

    // Squash source arbitration and next-state selection.
    always_comb begin
        ex_ok     = ex_vld_i && (s_eff != ST_TRAPW) && (ex_seq_i <= young_q);
        state_d   = s_eff;
        young_d   = young_q;
        bc_vld_d  = 1'b0;
        bc_seq_d  = '0;
        bc_pc_d   = '0;
        trap_load = 1'b0;
        enter_o   = 1'b0;
        if (full_sq) begin
            bc_vld_d = 1'b1;
            bc_seq_d = rob_empty_i ? '0 : rob_head_i - 1'b1;
            bc_pc_d  = restart_pc_i;
            young_d  = '0;
            state_d  = ST_SQUASH;
            enter_o  = (s_eff != ST_SQUASH);
        end else if (ex_ok) begin
            bc_vld_d = 1'b1;
            bc_seq_d = ex_incl_i ? ex_seq_i - 1'b1 : ex_seq_i;
            bc_pc_d  = ex_pc_i;
            young_d  = ex_incl_i ? ex_seq_i - 1'b1 : ex_seq_i;
            state_d  = ST_SQUASH;
            enter_o  = (s_eff != ST_SQUASH);
        end else begin
            if (insert_o)
                young_d = rename_seq_i;
            if (trap_req_i && s_eff != ST_TRAPW && s_eff != ST_SQUASH && !trap_busy) begin
                state_d   = ST_TRAPW;
                trap_load = 1'b1;
            end
        end
    end

    // State, youngest number and broadcast registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            young_q  <= '0;
            bc_vld_q <= 1'b0;
            bc_seq_q <= '0;
            bc_pc_q  <= '0;
        end else begin
            state_q  <= state_d;
            young_q  <= young_d;
            bc_vld_q <= bc_vld_d;
            bc_seq_q <= bc_seq_d;
            bc_pc_q  <= bc_pc_d;
        end
    end

    assign state_o  = state_q;
    assign bc_vld_o = bc_vld_q;
    assign bc_seq_o = bc_seq_q;
    assign bc_pc_o  = bc_pc_q;

    p_bc_means_squash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bc_vld_q |-> state_q == ST_SQUASH);
    p_stale_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_vld_i && ex_seq_i > young_q && !full_sq) |=> !bc_vld_q);
    p_trap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAPW && !trap_flag && !ctx_sq_i) |=> state_q == ST_TRAPW);
    p_full_clears_young_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full_sq |=> young_q == '0);
    p_fault_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAPW && !full_sq) |=> state_q != ST_FAULTW);
endmodule

// File: rtl/csq_counter.sv
// Count of threads in Squashing, updated from per-thread enter and
// leave pulses. Assumes a thread never enters twice without leaving.
module csq_counter #(
    parameter int NUM_THREADS = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_THREADS-1:0]             enter_i,
    input  logic [NUM_THREADS-1:0]             leave_i,
    output logic [$clog2(NUM_THREADS+1)-1:0]   cnt_o
);
    localparam int CW = $clog2(NUM_THREADS + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    // Net change from all threads this cycle.
    always_comb begin
        cnt_d = cnt_q;
        for (int t = 0; t < NUM_THREADS; t++) begin
            cnt_d = cnt_d + CW'(enter_i[t]) - CW'(leave_i[t]);
        end
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(NUM_THREADS));
endmodule

// File: rtl/commit_squash_ctrl.sv
// Top: one squash controller per thread plus the shared squashing count.
// Per-thread fields are packed with thread t at [t*W +: W].
module commit_squash_ctrl
    import csq_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int SEQ_W       = 6,
    parameter int PC_W        = 12,
    parameter int TRAP_LAT    = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_THREADS-1:0]           go_i,
    input  logic [NUM_THREADS-1:0]           rename_vld_i,
    input  logic [NUM_THREADS*SEQ_W-1:0]     rename_seq_i,
    input  logic [NUM_THREADS-1:0]           ex_vld_i,
    input  logic [NUM_THREADS*SEQ_W-1:0]     ex_seq_i,
    input  logic [NUM_THREADS-1:0]           ex_incl_i,
    input  logic [NUM_THREADS*PC_W-1:0]      ex_pc_i,
    input  logic [NUM_THREADS-1:0]           trap_req_i,
    input  logic [NUM_THREADS-1:0]           ctx_sq_i,
    input  logic [NUM_THREADS-1:0]           fault_i,
    input  logic [NUM_THREADS-1:0]           fault_clr_i,
    input  logic [NUM_THREADS-1:0]           rob_done_i,
    input  logic [NUM_THREADS-1:0]           rob_empty_i,
    input  logic [NUM_THREADS*SEQ_W-1:0]     rob_head_i,
    input  logic [NUM_THREADS*PC_W-1:0]      restart_pc_i,
    output logic [NUM_THREADS*ST_W-1:0]      state_o,
    output logic [NUM_THREADS-1:0]           bc_vld_o,
    output logic [NUM_THREADS*SEQ_W-1:0]     bc_seq_o,
    output logic [NUM_THREADS*PC_W-1:0]      bc_pc_o,
    output logic [NUM_THREADS-1:0]           insert_o,
    output logic [$clog2(NUM_THREADS+1)-1:0] sq_count_o
);
    logic [NUM_THREADS-1:0] enter, leave, squashing;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        thr_state_e st;

        csq_thread #(.SEQ_W(SEQ_W), .PC_W(PC_W), .TRAP_LAT(TRAP_LAT)) u_thr (
            .clk          (clk),
            .rst_n        (rst_n),
            .go_i         (go_i[t]),
            .rename_vld_i (rename_vld_i[t]),
            .rename_seq_i (rename_seq_i[t*SEQ_W +: SEQ_W]),
            .ex_vld_i     (ex_vld_i[t]),
            .ex_seq_i     (ex_seq_i[t*SEQ_W +: SEQ_W]),
            .ex_incl_i    (ex_incl_i[t]),
            .ex_pc_i      (ex_pc_i[t*PC_W +: PC_W]),
            .trap_req_i   (trap_req_i[t]),
            .ctx_sq_i     (ctx_sq_i[t]),
            .fault_i      (fault_i[t]),
            .fault_clr_i  (fault_clr_i[t]),
            .rob_done_i   (rob_done_i[t]),
            .rob_empty_i  (rob_empty_i[t]),
            .rob_head_i   (rob_head_i[t*SEQ_W +: SEQ_W]),
            .restart_pc_i (restart_pc_i[t*PC_W +: PC_W]),
            .state_o      (st),
            .bc_vld_o     (bc_vld_o[t]),
            .bc_seq_o     (bc_seq_o[t*SEQ_W +: SEQ_W]),
            .bc_pc_o      (bc_pc_o[t*PC_W +: PC_W]),
            .insert_o     (insert_o[t]),
            .enter_o      (enter[t]),
            .leave_o      (leave[t])
        );

        assign state_o[t*ST_W +: ST_W] = st;
        assign squashing[t]            = (st == ST_SQUASH);
    end

    csq_counter #(.NUM_THREADS(NUM_THREADS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .enter_i (enter),
        .leave_i (leave),
        .cnt_o   (sq_count_o)
    );

    p_cnt_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sq_count_o == $bits(sq_count_o)'($countones(squashing)));
endmodule

// File: tb/commit_squash_ctrl_tb_top.sv
`timescale 1ns/1ps
// Behavioural reference model compared against the controller every cycle.
module commit_squash_ctrl_tb_top;
    localparam int NT = 2;
    localparam int SW = 6;
    localparam int PW = 12;
    localparam int TL = 3;
    localparam int CW = $clog2(NT + 1);
    localparam int SM = (1 << SW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT-1:0] go, rvld, exv, exi, trq, ctx, flt, fclr, done, emp;
    logic [NT*SW-1:0] rseq, exs, head;
    logic [NT*PW-1:0] expc, rpc;
    logic [NT*3-1:0] st_o;
    logic [NT-1:0] bv_o, ins_o;
    logic [NT*SW-1:0] bs_o;
    logic [NT*PW-1:0] bp_o;
    logic [CW-1:0] cnt_o;

    always #10 clk = ~clk;

    commit_squash_ctrl #(.NUM_THREADS(NT), .SEQ_W(SW), .PC_W(PW), .TRAP_LAT(TL)) dut_i (
        .clk(clk), .rst_n(rst_n), .go_i(go), .rename_vld_i(rvld), .rename_seq_i(rseq),
        .ex_vld_i(exv), .ex_seq_i(exs), .ex_incl_i(exi), .ex_pc_i(expc),
        .trap_req_i(trq), .ctx_sq_i(ctx), .fault_i(flt), .fault_clr_i(fclr),
        .rob_done_i(done), .rob_empty_i(emp), .rob_head_i(head), .restart_pc_i(rpc),
        .state_o(st_o), .bc_vld_o(bv_o), .bc_seq_o(bs_o), .bc_pc_o(bp_o),
        .insert_o(ins_o), .sq_count_o(cnt_o));

    int errors = 0, checks = 0;
    string cur_req = "R1";
    int m_st[NT], m_yg[NT], m_tm[NT], m_fl[NT], m_bv[NT], m_bs[NT], m_bp[NT];
    int m_cnt;
    bit finished = 0;

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            m_st[t] = 0; m_yg[t] = 0; m_tm[t] = 0; m_fl[t] = 0;
            m_bv[t] = 0; m_bs[t] = 0; m_bp[t] = 0;
        end
        m_cnt = 0;
    endtask

    task automatic model_step();
        for (int t = 0; t < NT; t++) begin
            int s, ns, ins, nfl;
            s = m_st[t];
            ins = rvld[t] && m_st[t] != 2;
            if (s == 2 && done[t]) begin s = 1; m_cnt--; end
            if (s == 0 && go[t]) s = 1;
            if (flt[t] && s != 3 && s != 2) s = 4;
            if (fclr[t] && s == 4) s = 1;
            ns = s;
            nfl = (m_tm[t] == 1) ? 1 : m_fl[t];
            if (m_tm[t] > 0) m_tm[t]--;
            m_bv[t] = 0; m_bs[t] = 0; m_bp[t] = 0;
            if (m_fl[t] || ctx[t]) begin
                if (m_tm[t] == 0 && m_fl[t]) nfl = 0;
                else if (m_fl[t]) nfl = 0;
                m_bv[t] = 1;
                m_bs[t] = emp[t] ? 0 : ((int'(head[t*SW +: SW]) - 1) & SM);
                m_bp[t] = rpc[t*PW +: PW];
                m_yg[t] = 0;
                ns = 2;
                if (s != 2) m_cnt++;
            end else if (exv[t] && s != 3 && int'(exs[t*SW +: SW]) <= m_yg[t]) begin
                m_bv[t] = 1;
                m_bs[t] = exi[t] ? ((int'(exs[t*SW +: SW]) - 1) & SM) : int'(exs[t*SW +: SW]);
                m_bp[t] = expc[t*PW +: PW];
                m_yg[t] = m_bs[t];
                ns = 2;
                if (s != 2) m_cnt++;
            end else begin
                if (ins) m_yg[t] = rseq[t*SW +: SW];
                if (trq[t] && s != 3 && s != 2 && m_tm[t] == 0 && !(nfl && !m_fl[t])) begin
                    ns = 3;
                    m_tm[t] = TL;
                end
            end
            m_fl[t] = nfl;
            m_st[t] = ns;
        end
    endtask

    task automatic compare_regs();
        for (int t = 0; t < NT; t++) begin
            chk($sformatf("t%0d state", t), st_o[t*3 +: 3], m_st[t]);
            chk($sformatf("t%0d bc_vld", t), bv_o[t], m_bv[t]);
            chk($sformatf("t%0d bc_seq", t), bs_o[t*SW +: SW], m_bs[t]);
            chk($sformatf("t%0d bc_pc", t), bp_o[t*PW +: PW], m_bp[t]);
        end
        chk("sq_count", cnt_o, m_cnt);
    endtask

    task automatic clear_in();
        go = '0; rvld = '0; exv = '0; exi = '0; trq = '0; ctx = '0; flt = '0;
        fclr = '0; done = '0; emp = '0; rseq = '0; exs = '0; head = '0;
        expc = '0; rpc = '0;
    endtask

    task automatic cyc();
        #1;
        for (int t = 0; t < NT; t++)
            chk($sformatf("t%0d insert", t), ins_o[t], (rvld[t] && m_st[t] != 2) ? 1 : 0);
        @(posedge clk);
        if (rst_n) model_step(); else model_reset();
        @(negedge clk);
        compare_regs();
        clear_in();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 20000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        clear_in();
        model_reset();
        @(negedge clk);
        cyc(); cyc();
        rst_n = 1'b1;
        cur_req = "R1"; cyc();
        cur_req = "R2"; go = 2'b11; cyc(); cyc();
        cur_req = "R11";
        rvld = 2'b11; rseq = {6'd20, 6'd10}; cyc(); cyc();
        cur_req = "R3";
        exv[0] = 1; exs[5:0] = 6'd8; expc[11:0] = 12'h123; cyc();
        cur_req = "R11"; rvld[0] = 1; rseq[5:0] = 6'd40; cyc();
        cur_req = "R5"; exv[0] = 1; exs[5:0] = 6'd50; cyc();
        cur_req = "R9"; done[0] = 1; cyc(); cyc();
        cur_req = "R4";
        exv[1] = 1; exi[1] = 1; exs[11:6] = 6'd20; expc[23:12] = 12'hABC; cyc();
        cur_req = "R12"; cyc(); cyc();
        cur_req = "R9"; done[1] = 1; cyc();
        cur_req = "R6"; trq[0] = 1; cyc();
        exv[0] = 1; exs[5:0] = 6'd0; flt[0] = 1; rpc[11:0] = 12'h055; cyc();
        cyc(); emp[0] = 1; rpc[11:0] = 12'h077; cyc(); cyc();
        cur_req = "R9"; done[0] = 1; cyc();
        cur_req = "R7"; ctx[1] = 1; emp[1] = 0; head[11:6] = 6'd0; rpc[23:12] = 12'h9F0; cyc();
        done[1] = 1; cyc();
        ctx[1] = 1; emp[1] = 1; rpc[23:12] = 12'h111; cyc();
        done[1] = 1; cyc();
        cur_req = "R8"; trq[0] = 1; cyc();
        cyc(); cyc(); cyc();
        ctx[0] = 1; head[5:0] = 6'd33; rpc[11:0] = 12'h321; cyc(); cyc();
        done[0] = 1; cyc();
        cur_req = "R10"; flt[1] = 1; cyc(); cyc();
        fclr[1] = 1; cyc();
        trq[1] = 1; cyc(); flt[1] = 1; cyc(); cyc(); cyc(); done[1] = 1; cyc();
        ctx[0] = 1; cyc(); flt[0] = 1; cyc(); done[0] = 1; cyc();
        cur_req = "R12";
        for (int i = 0; i < 600; i++) begin
            for (int t = 0; t < NT; t++) begin
                go[t]   = ($urandom_range(0, 7) == 0);
                rvld[t] = ($urandom_range(0, 1) == 0);
                exv[t]  = ($urandom_range(0, 3) == 0);
                exi[t]  = ($urandom_range(0, 1) == 0);
                trq[t]  = ($urandom_range(0, 11) == 0);
                ctx[t]  = ($urandom_range(0, 19) == 0);
                flt[t]  = ($urandom_range(0, 9) == 0);
                fclr[t] = ($urandom_range(0, 5) == 0);
                done[t] = ($urandom_range(0, 2) == 0);
                emp[t]  = ($urandom_range(0, 3) == 0);
                rseq[t*SW +: SW] = SW'($urandom_range(0, SM));
                exs[t*SW +: SW]  = SW'($urandom_range(0, SM));
                head[t*SW +: SW] = SW'($urandom_range(0, SM));
                expc[t*PW +: PW] = PW'($urandom);
                rpc[t*PW +: PW]  = PW'($urandom);
            end
            cyc();
        end
        finish_run();
    end
endmodule